// File: doc/BRIEF.md
# Processor Status Flags with Interrupt Masking

This block holds the five status bits of an 8-bit processor core: half carry, interrupt mask, negative, zero and carry. On each clock it folds the result of the ALU operation that just finished into the flags. Which flags change depends on the class of the operation and on a per-flag write enable from the decoder. The carry out of the low nibble feeds the half carry bit. The carry out of the top bit feeds the carry flag.

The same block decides which interrupt the core may take next. Each request line gives a one-cycle pulse. The pulse is held in a one-bit latch for that source until the core takes it. While the mask bit is 1, no held request is offered to the core. The software trap is the one exception: it is offered whatever the mask says, and it comes before every other source. When the mask is 0, the held request with the lowest index is offered. When the core acknowledges an offered interrupt, that latch is cleared and the mask is set. Instructions can also set, clear or load the mask directly.

Top module: `ccr_top`

## Requirements
- R1: The status vector `ccr` packs carry at bit 0, zero at bit 1, negative at bit 2, mask at bit 3 and half carry at bit 4. In the cycle after reset it reads 5'b01000, and nothing is offered (`irq_valid` low).
- R2: The half carry bit takes `c_lo` only when `op_class` is 1 (add or add-with-carry) and `upd_h` is high.
- R3: The negative bit takes `res[7]`, and the zero bit takes (`res` == 0). Each changes only when its enable (`upd_n` or `upd_z`) is high and `op_class` is 1 (add), 2 (subtract/compare), 3 (logical) or 4 (data move/manipulation).
- R4: The carry bit takes `c_hi` only when `upd_c` is high and `op_class` is 1, 2 or 5. Class 5 covers bit test, branch, shift, rotate and store.
- R5: A flag whose enable is low, or whose enable is high under an `op_class` that does not write it, keeps its value. Class 0 writes no flag.
- R6: The mask bit is written in this order of precedence: set by a taken interrupt, then by `imask_set`, then cleared by `imask_clr`, then loaded from `imask_val` by `imask_load`.
- R7: A pulse on `irq_in[k]` is held until that source is taken, and a second pulse before then adds nothing. While the mask is 1, `irq_valid` stays low unless a trap is held.
- R8: When the mask is 0 and no trap is held, `irq_valid` is high whenever any source is held, and `irq_id` names the lowest-index held source.
- R9: A pulse on `trap_in` is held, and it drives `irq_valid` and `irq_trap` high whatever the mask says. It is offered before any source.
- R10: `int_ack` while `irq_valid` is high clears the held trap, or if there is none the latch named by `irq_id`, and sets the mask. `int_ack` while `irq_valid` is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| res | input | DATA_W | ALU result of the finishing operation |
| c_lo | input | 1 | Carry from bit 3 into bit 4 |
| c_hi | input | 1 | Carry or borrow out of the top bit |
| op_class | input | 3 | Operation class, codes 0..5 |
| upd_h | input | 1 | Write enable, half carry |
| upd_n | input | 1 | Write enable, negative |
| upd_z | input | 1 | Write enable, zero |
| upd_c | input | 1 | Write enable, carry |
| imask_set | input | 1 | Set the mask bit |
| imask_clr | input | 1 | Clear the mask bit |
| imask_load | input | 1 | Load the mask bit from imask_val |
| imask_val | input | 1 | Value for imask_load |
| irq_in | input | N_SRC | Request pulses, one per source |
| trap_in | input | 1 | Software trap pulse |
| int_ack | input | 1 | Core takes the offered interrupt |
| ccr | output | 5 | Status bits {H,I,N,Z,C} |
| irq_valid | output | 1 | An interrupt is offered |
| irq_trap | output | 1 | The offered interrupt is the trap |
| irq_id | output | $clog2(N_SRC) | Index of the offered source |

## Verification
Every flag, latch and mask update lands at the first rising edge after the inputs that cause it. The offer outputs are decoded without delay from those registers, so a request or an acknowledge shows on `irq_valid` and `irq_id` in the very next cycle. The bench drives inputs at the falling edge and moves its model one step at once. It then compares every output at the next falling edge, so each result is checked exactly one edge after its cause. `irq_id` is compared only while a source, not the trap, is offered.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  typedef enum logic [2:0] {
    OPC_NOP   = 3'd0,
    OPC_ADD   = 3'd1,
    OPC_SUB   = 3'd2,
    OPC_LOGIC = 3'd3,
    OPC_MOVE  = 3'd4,
    OPC_CAUX  = 3'd5
  } op_class_t;

  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_N = 2;
  localparam int FLAG_I = 3;
  localparam int FLAG_H = 4;
  localparam int FLAGS_W = 5;

  function automatic logic writes_nz(input logic [2:0] oc);
    return (oc == OPC_ADD) || (oc == OPC_SUB) || (oc == OPC_LOGIC) || (oc == OPC_MOVE);
  endfunction

  function automatic logic writes_c(input logic [2:0] oc);
    return (oc == OPC_ADD) || (oc == OPC_SUB) || (oc == OPC_CAUX);
  endfunction
endpackage

// File: rtl/ccr_flag_unit.sv
module ccr_flag_unit #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] res,
  input  logic              c_lo,
  input  logic              c_hi,
  input  logic [2:0]        op_class,
  input  logic              upd_h,
  input  logic              upd_n,
  input  logic              upd_z,
  input  logic              upd_c,
  output logic              h_q,
  output logic              n_q,
  output logic              z_q,
  output logic              c_q
);
  import ccr_pkg::*;

  logic nz_cls;
  logic c_cls;
  logic h_cls;

  always_comb begin
    nz_cls = writes_nz(op_class);
    c_cls  = writes_c(op_class);
    h_cls  = (op_class == OPC_ADD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_q <= 1'b0;
      n_q <= 1'b0;
      z_q <= 1'b0;
      c_q <= 1'b0;
    end else begin
      if (upd_h && h_cls)  h_q <= c_lo;
      if (upd_n && nz_cls) n_q <= res[DATA_W-1];
      if (upd_z && nz_cls) z_q <= ~|res;
      if (upd_c && c_cls)  c_q <= c_hi;
    end
  end
endmodule

// File: rtl/ccr_mask_bit.sv
module ccr_mask_bit (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic imask_set,
  input  logic imask_clr,
  input  logic imask_load,
  input  logic imask_val,
  output logic i_q
);
  always_ff @(posedge clk) begin
    if (rst)             i_q <= 1'b1;
    else if (take)       i_q <= 1'b1;
    else if (imask_set)  i_q <= 1'b1;
    else if (imask_clr)  i_q <= 1'b0;
    else if (imask_load) i_q <= imask_val;
  end
endmodule

// File: rtl/ccr_irq_latch.sv
module ccr_irq_latch #(
  parameter int N_SRC = 8,
  localparam int IDW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_in,
  input  logic             trap_in,
  input  logic             i_bit,
  input  logic             take,
  output logic             irq_valid,
  output logic             irq_trap,
  output logic [IDW-1:0]   irq_id
);
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] drop;
  logic             trap_q;
  logic [IDW-1:0]   low_id;

  always_comb begin
    low_id = '0;
    for (int k = N_SRC - 1; k >= 0; k--) begin
      if (pend_q[k]) low_id = IDW'(k);
    end
  end

  always_comb begin
    drop = '0;
    if (take && !trap_q) drop[low_id] = 1'b1;
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) pend_q[g] <= 1'b0;
      else     pend_q[g] <= (pend_q[g] & ~drop[g]) | irq_in[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) trap_q <= 1'b0;
    else     trap_q <= (trap_q & ~take) | trap_in;
  end

  assign irq_trap  = trap_q;
  assign irq_valid = trap_q | (~i_bit & |pend_q);
  assign irq_id    = low_id;
endmodule

// File: rtl/ccr_top.sv
module ccr_top #(
  parameter int DATA_W = 8,
  parameter int N_SRC  = 8,
  localparam int IDW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] res,
  input  logic              c_lo,
  input  logic              c_hi,
  input  logic [2:0]        op_class,
  input  logic              upd_h,
  input  logic              upd_n,
  input  logic              upd_z,
  input  logic              upd_c,
  input  logic              imask_set,
  input  logic              imask_clr,
  input  logic              imask_load,
  input  logic              imask_val,
  input  logic [N_SRC-1:0]  irq_in,
  input  logic              trap_in,
  input  logic              int_ack,
  output logic [4:0]        ccr,
  output logic              irq_valid,
  output logic              irq_trap,
  output logic [IDW-1:0]    irq_id
);
  import ccr_pkg::*;

  logic h_q, n_q, z_q, c_q, i_q;
  logic offer;
  logic take;

  assign take = int_ack & offer;

  ccr_flag_unit #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst(rst), .res(res), .c_lo(c_lo), .c_hi(c_hi),
    .op_class(op_class), .upd_h(upd_h), .upd_n(upd_n), .upd_z(upd_z),
    .upd_c(upd_c), .h_q(h_q), .n_q(n_q), .z_q(z_q), .c_q(c_q)
  );

  ccr_mask_bit u_mask (
    .clk(clk), .rst(rst), .take(take), .imask_set(imask_set),
    .imask_clr(imask_clr), .imask_load(imask_load), .imask_val(imask_val),
    .i_q(i_q)
  );

  ccr_irq_latch #(.N_SRC(N_SRC)) u_irq (
    .clk(clk), .rst(rst), .irq_in(irq_in), .trap_in(trap_in), .i_bit(i_q),
    .take(take), .irq_valid(offer), .irq_trap(irq_trap), .irq_id(irq_id)
  );

  always_comb begin
    ccr = '0;
    ccr[FLAG_C] = c_q;
    ccr[FLAG_Z] = z_q;
    ccr[FLAG_N] = n_q;
    ccr[FLAG_I] = i_q;
    ccr[FLAG_H] = h_q;
  end

  assign irq_valid = offer;
endmodule

// File: rtl/ccr_top_chk.sv
module ccr_top_chk #(
  parameter int DATA_W = 8,
  parameter int N_SRC  = 8,
  localparam int IDW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] res,
  input logic              c_lo,
  input logic              c_hi,
  input logic [2:0]        op_class,
  input logic              upd_h,
  input logic              upd_z,
  input logic              upd_c,
  input logic              int_ack,
  input logic [4:0]        ccr,
  input logic              irq_valid,
  input logic              irq_trap
);
  logic seen;
  always_ff @(posedge clk) seen <= 1'b1;

  p_reset_val_r1: assert property (@(posedge clk)
    seen && $past(rst) |-> (ccr == 5'b01000) && !irq_valid);

  p_h_only_add_r2: assert property (@(posedge clk) disable iff (rst)
    (op_class == 3'd1 && upd_h) |=> ccr[4] == $past(c_lo));

  p_h_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(op_class == 3'd1 && upd_h) |=> $stable(ccr[4]));

  p_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (upd_z && op_class >= 3'd1 && op_class <= 3'd4) |=> ccr[1] == ($past(res) == '0));

  p_carry_r4: assert property (@(posedge clk) disable iff (rst)
    (upd_c && (op_class == 3'd1 || op_class == 3'd2 || op_class == 3'd5))
      |=> ccr[0] == $past(c_hi));

  p_masked_r7: assert property (@(posedge clk) disable iff (rst)
    (ccr[3] && !irq_trap) |-> !irq_valid);

  p_trap_bypass_r9: assert property (@(posedge clk) disable iff (rst)
    irq_trap |-> irq_valid);

  p_take_sets_i_r10: assert property (@(posedge clk) disable iff (rst)
    (int_ack && irq_valid) |=> ccr[3]);
endmodule

bind ccr_top ccr_top_chk #(.DATA_W(DATA_W), .N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst(rst), .res(res), .c_lo(c_lo), .c_hi(c_hi),
  .op_class(op_class), .upd_h(upd_h), .upd_z(upd_z), .upd_c(upd_c),
  .int_ack(int_ack), .ccr(ccr), .irq_valid(irq_valid), .irq_trap(irq_trap)
);

// File: tb/ccr_top_tb_top.sv
module ccr_top_tb_top;
  localparam int DATA_W = 8;
  localparam int N_SRC  = 8;
  localparam int IDW    = $clog2(N_SRC);

  logic clk = 1'b0;
  logic rst;
  logic [DATA_W-1:0] res;
  logic c_lo, c_hi;
  logic [2:0] op_class;
  logic upd_h, upd_n, upd_z, upd_c;
  logic imask_set, imask_clr, imask_load, imask_val;
  logic [N_SRC-1:0] irq_in;
  logic trap_in, int_ack;
  logic [4:0] ccr;
  logic irq_valid, irq_trap;
  logic [IDW-1:0] irq_id;

  always #2.5 clk = ~clk;

  ccr_top #(.DATA_W(DATA_W), .N_SRC(N_SRC)) dut_i (
    .clk(clk), .rst(rst), .res(res), .c_lo(c_lo), .c_hi(c_hi),
    .op_class(op_class), .upd_h(upd_h), .upd_n(upd_n), .upd_z(upd_z),
    .upd_c(upd_c), .imask_set(imask_set), .imask_clr(imask_clr),
    .imask_load(imask_load), .imask_val(imask_val), .irq_in(irq_in),
    .trap_in(trap_in), .int_ack(int_ack), .ccr(ccr), .irq_valid(irq_valid),
    .irq_trap(irq_trap), .irq_id(irq_id)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  bit [4:0] m_ccr;
  bit [N_SRC-1:0] m_pend;
  bit m_trap;

  task automatic check(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
    end
  endtask

  function automatic bit m_valid();
    return m_trap || (!m_ccr[3] && (m_pend != 0));
  endfunction

  function automatic int m_low();
    for (int k = 0; k < N_SRC; k++) if (m_pend[k]) return k;
    return 0;
  endfunction

  // Advance the model by one edge using the current inputs.
  task automatic model_step();
    bit take;
    int lo;
    take = int_ack && m_valid();
    lo = m_low();
    if (rst) begin
      m_ccr = 5'b01000; m_pend = '0; m_trap = 1'b0;
      return;
    end
    if (upd_h && op_class == 3'd1) m_ccr[4] = c_lo;
    if (upd_n && op_class >= 3'd1 && op_class <= 3'd4) m_ccr[2] = res[DATA_W-1];
    if (upd_z && op_class >= 3'd1 && op_class <= 3'd4) m_ccr[1] = (res == 0);
    if (upd_c && (op_class == 3'd1 || op_class == 3'd2 || op_class == 3'd5)) m_ccr[0] = c_hi;
    if (take) m_ccr[3] = 1'b1;
    else if (imask_set) m_ccr[3] = 1'b1;
    else if (imask_clr) m_ccr[3] = 1'b0;
    else if (imask_load) m_ccr[3] = imask_val;
    if (take && m_trap) m_trap = 1'b0;
    else if (take) m_pend[lo] = 1'b0;
    m_pend = m_pend | irq_in;
    if (trap_in) m_trap = 1'b1;
  endtask

  task automatic compare_all();
    check("R2", ccr[4], m_ccr[4]);
    check("R6", ccr[3], m_ccr[3]);
    check("R3", ccr[2], m_ccr[2]);
    check("R3", ccr[1], m_ccr[1]);
    check("R4", ccr[0], m_ccr[0]);
    check("R7", irq_valid, m_valid());
    check("R9", irq_trap, m_trap);
    if (m_valid() && !m_trap) check("R8", irq_id, m_low());
  endtask

  task automatic idle();
    res = '0; c_lo = 0; c_hi = 0; op_class = 3'd0;
    upd_h = 0; upd_n = 0; upd_z = 0; upd_c = 0;
    imask_set = 0; imask_clr = 0; imask_load = 0; imask_val = 0;
    irq_in = '0; trap_in = 0; int_ack = 0;
  endtask

  // Apply current inputs for one edge, then compare at the next falling edge.
  task automatic cycle();
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    bit [4:0] keep;
    idle();
    rst = 1;
    @(negedge clk);
    model_step();
    @(negedge clk);
    model_step();
    @(negedge clk);
    rst = 0;
    check("R1", ccr, 5'b01000);
    check("R1", irq_valid, 0);

    // R2: add writes H from c_lo, subtract does not
    op_class = 3'd1; upd_h = 1; c_lo = 1; cycle();
    check("R2", ccr[4], 1);
    op_class = 3'd2; c_lo = 0; cycle();
    check("R2", ccr[4], 1);
    idle();

    // R3: negative and zero from result
    op_class = 3'd3; upd_n = 1; upd_z = 1; res = 8'h80; cycle();
    check("R3", ccr[2:1], 2'b10);
    res = 8'h00; op_class = 3'd4; cycle();
    check("R3", ccr[2:1], 2'b01);
    idle();

    // R4: carry from shift class, not from logical class
    op_class = 3'd5; upd_c = 1; c_hi = 1; cycle();
    check("R4", ccr[0], 1);
    op_class = 3'd3; c_hi = 0; cycle();
    check("R4", ccr[0], 1);
    idle();

    // R5: class 0 with every enable high leaves flags alone
    keep = ccr;
    op_class = 3'd0; upd_h = 1; upd_n = 1; upd_z = 1; upd_c = 1;
    res = 8'hFF; c_lo = 0; c_hi = 0; cycle();
    check("R5", ccr, keep);
    idle();

    // R7: masked requests are held, not offered
    irq_in = 8'b0010_1000; cycle();
    check("R7", irq_valid, 0);
    irq_in = 8'b0000_1000; cycle();
    irq_in = '0; cycle();
    check("R7", irq_valid, 0);

    // R6: clear beats load; R8: lowest held source offered
    imask_clr = 1; imask_load = 1; imask_val = 1; cycle();
    idle();
    check("R6", ccr[3], 0);
    check("R8", irq_valid, 1);
    check("R8", irq_id, 3);

    // R10: take source 3, mask set, source 5 still held
    int_ack = 1; cycle(); idle();
    check("R10", ccr[3], 1);
    check("R10", irq_valid, 0);
    imask_clr = 1; cycle(); idle();
    check("R10", irq_id, 5);
    int_ack = 1; cycle(); idle();
    imask_load = 1; imask_val = 0; cycle(); idle();
    check("R10", irq_valid, 0);
    // ack while nothing offered changes nothing
    keep = ccr;
    int_ack = 1; cycle(); idle();
    check("R10", ccr, keep);

    // R9: trap passes the mask and comes before sources
    imask_set = 1; irq_in = 8'b0000_0001; trap_in = 1; cycle(); idle();
    check("R9", irq_valid, 1);
    check("R9", irq_trap, 1);
    int_ack = 1; cycle(); idle();
    check("R9", irq_trap, 0);
    check("R9", irq_valid, 0);
    imask_clr = 1; cycle(); idle();
    check("R8", irq_id, 0);
    int_ack = 1; cycle(); idle();

    // Random traffic compared every cycle
    for (int t = 0; t < 3000; t++) begin
      res = DATA_W'($urandom);
      c_lo = 1'($urandom); c_hi = 1'($urandom);
      op_class = 3'($urandom_range(0, 6));
      upd_h = 1'($urandom); upd_n = 1'($urandom);
      upd_z = 1'($urandom); upd_c = 1'($urandom);
      imask_set = ($urandom_range(0, 9) == 0);
      imask_clr = ($urandom_range(0, 4) == 0);
      imask_load = ($urandom_range(0, 9) == 0);
      imask_val = 1'($urandom);
      irq_in = '0;
      for (int k = 0; k < N_SRC; k++) irq_in[k] = ($urandom_range(0, 11) == 0);
      trap_in = ($urandom_range(0, 40) == 0);
      int_ack = ($urandom_range(0, 2) == 0);
      cycle();
    end
    idle();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule